// File: doc/BRIEF.md
# Sleep-Mode Wakeup Interrupt Capture Controller

This block watches a set of wakeup interrupt lines while the main interrupt controller is powered down or bypassed, and holds every qualifying event in a sticky status bit so that software can replay it later. The lines are grouped into 32-line banks. Each line has its own mask bit, its own polarity bit and its own sensitivity bit (edge or level). Every line passes through a two-flop synchronizer before it is qualified.

A small register port sets up the lines, reads the captured status and acknowledges it. A control state machine has three states. ST_IDLE means capture is off. ST_ARMED means capture is on. ST_FLUSH lasts one cycle and wipes all captured status. The transitions are:
- ST_IDLE goes to ST_ARMED when the enable bit is written as 1.
- ST_ARMED goes to ST_IDLE when the enable bit is written as 0.
- Any state goes to ST_FLUSH when the software-reset bit is written as 1.
- ST_FLUSH goes to ST_ARMED or to ST_IDLE, following the enable bit that is held.

A per-bank pending output shows which banks hold captured events.

Top module: `wake_capture_ctrl`

## Requirements
- R1: After reset, all mask bits read 1, all polarity and sensitivity bits read 0, all status bits read 0, the control register reads 0 and pend_out is 0.
- R2: Line n is bit n%32 of bank n/32. Register group g sits at byte offset g*0x10, and bank b of that group sits at +4*b. The groups are 0 control, 1 mask-set, 2 mask-clear, 3 polarity-set, 4 polarity-clear, 5 sensitivity, 6 sensitivity-clear, 7 acknowledge and 8 status. The set and clear groups read back the register they modify.
- R3: A 1 written to mask-set masks that line, and a 1 written to mask-clear unmasks it. Zero bits leave their lines unchanged. A masked line never captures.
- R4: A 1 written to polarity-set selects positive (rising or high) for that line, and a 1 written to polarity-clear selects negative (falling or low). The sensitivity register is written whole, with 1 meaning level and 0 meaning edge. A 1 written to sensitivity-clear switches that line to edge.
- R5: An unmasked edge line captures on a rising synchronized input when its polarity is positive, and on a falling one when its polarity is negative. The status bit sets within four clock edges of the input change.
- R6: An unmasked level line captures whenever its synchronized input equals its polarity bit.
- R7: Control bit 0 is the global enable. While it is 0 no status bit is set. It reads back at bit 0 of the control register.
- R8: Writing 1 to control bit 1 clears every status bit through a one-cycle flush. The enable written in the same word is kept, and bit 1 reads back 0.
- R9: A 1 written to the acknowledge register clears that status bit, and zero bits leave status unchanged. When a capture and an acknowledge hit the same bit in the same cycle, the bit stays set.
- R10: pend_out[b] is 1 exactly when any status bit of bank b is set.
- R11: A write to an unmapped offset is ignored. This covers an unused group, a bank index of NUM_BANKS or more, and a byte address that is not word-aligned. Such an offset, and the acknowledge group, read back zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| irq_in | input | NUM_BANKS*32 | Asynchronous wakeup interrupt lines |
| pend_out | output | NUM_BANKS | Per-bank captured-event flag |

## Verification
Each kind of wrong internal state shows up at the ports in its own way:
- A wrong mask, polarity or sensitivity bit produces a status bit that is missing or extra. This is visible on the status read and on pend_out about four cycles after the input moves.
- A control state machine stuck in the wrong state either captures while disabled or misses every later event. The disabled-capture and post-flush checks expose this on the next input edge.
- A broken set-versus-acknowledge priority appears the cycle after an acknowledge, as a level line whose status read comes back clear.

// File: rtl/wcc_pkg.sv
package wcc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_FLUSH = 2'd2
    } wcc_state_e;

    localparam logic [3:0] G_CTRL = 4'h0;
    localparam logic [3:0] G_MSET = 4'h1;
    localparam logic [3:0] G_MCLR = 4'h2;
    localparam logic [3:0] G_PSET = 4'h3;
    localparam logic [3:0] G_PCLR = 4'h4;
    localparam logic [3:0] G_SENS = 4'h5;
    localparam logic [3:0] G_SCLR = 4'h6;
    localparam logic [3:0] G_ACK  = 4'h7;
    localparam logic [3:0] G_STAT = 4'h8;
endpackage

// File: rtl/wcc_fsm.sv
module wcc_fsm
    import wcc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ctrl_wr,
    input  logic ctrl_en_bit,
    input  logic ctrl_rst_bit,
    output logic en_q,
    output logic cap_en,
    output logic flush
);
    wcc_state_e state, nxt;
    logic en_next;

    assign en_next = ctrl_wr ? ctrl_en_bit : en_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            en_q  <= 1'b0;
        end else begin
            state <= nxt;
            en_q  <= en_next;
        end
    end

    always_comb begin
        nxt = state;
        if (ctrl_wr && ctrl_rst_bit) begin
            nxt = ST_FLUSH;
        end else begin
            unique case (state)
                ST_IDLE:  if (ctrl_wr && ctrl_en_bit)  nxt = ST_ARMED;
                ST_ARMED: if (ctrl_wr && !ctrl_en_bit) nxt = ST_IDLE;
                ST_FLUSH: nxt = en_next ? ST_ARMED : ST_IDLE;
                default:  nxt = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        cap_en = (state == ST_ARMED);
        flush  = (state == ST_FLUSH);
    end

    // R8: the flush lasts a single cycle unless it is requested again
    p_flush_one_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FLUSH && !(ctrl_wr && ctrl_rst_bit)) |=> (state != ST_FLUSH));
    // R7: capture is only armed while the enable bit is held
    p_armed_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cap_en |-> en_q);
endmodule

// File: rtl/wcc_line_qual.sv
module wcc_line_qual #(
    parameter int NUM_LINES = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_in,
    input  logic [NUM_LINES-1:0] mask,
    input  logic [NUM_LINES-1:0] pol,
    input  logic [NUM_LINES-1:0] sens,
    input  logic                 cap_en,
    output logic [NUM_LINES-1:0] cap
);
    logic [NUM_LINES-1:0] s1_q, s2_q, prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q   <= '0;
            s2_q   <= '0;
            prev_q <= '0;
        end else begin
            s1_q   <= irq_in;
            s2_q   <= s1_q;
            prev_q <= s2_q;
        end
    end

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        logic edge_hit, lvl_hit;
        assign edge_hit = pol[i] ? (s2_q[i] & ~prev_q[i]) : (~s2_q[i] & prev_q[i]);
        assign lvl_hit  = (s2_q[i] == pol[i]);
        assign cap[i]   = cap_en & ~mask[i] & (sens[i] ? lvl_hit : edge_hit);
    end
endmodule

// File: rtl/wcc_regfile.sv
module wcc_regfile
    import wcc_pkg::*;
#(
    parameter int NUM_BANKS = 2,
    localparam int NL   = NUM_BANKS * 32,
    localparam int BK_W = $clog2(NUM_BANKS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_sel,
    input  logic                 bus_wr,
    input  logic [7:0]           bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    input  logic [NL-1:0]        cap,
    input  logic                 flush,
    input  logic                 en_q,
    output logic                 ctrl_wr,
    output logic                 ctrl_en_bit,
    output logic                 ctrl_rst_bit,
    output logic [NL-1:0]        mask,
    output logic [NL-1:0]        pol,
    output logic [NL-1:0]        sens,
    output logic [NL-1:0]        status,
    output logic [NUM_BANKS-1:0] pend_out
);
    // NUM_BANKS is limited to 2..4 by the two-bit bank field of the address
    logic [3:0]      grp;
    logic [1:0]      bk;
    logic [BK_W-1:0] bk_i;
    logic            bank_ok, wr_go;

    logic [NUM_BANKS-1:0][31:0] mask_q, pol_q, sens_q, stat_q;
    logic [NUM_BANKS-1:0][31:0] mset, mclr, pset, pclr, sclr, sw_m, sw_d, ack_v;

    assign grp     = bus_addr[7:4];
    assign bk      = bus_addr[3:2];
    assign bk_i    = BK_W'(bk);
    assign bank_ok = (bus_addr[1:0] == 2'b00) && (32'(bk) < NUM_BANKS);
    assign wr_go   = bus_sel & bus_wr & bank_ok;

    assign ctrl_wr      = bus_sel & bus_wr & (bus_addr == 8'h00);
    assign ctrl_en_bit  = bus_wdata[0];
    assign ctrl_rst_bit = bus_wdata[1];

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic hit;
        assign hit      = wr_go && (bk == 2'(b));
        assign mset[b]  = (hit && grp == G_MSET) ? bus_wdata : '0;
        assign mclr[b]  = (hit && grp == G_MCLR) ? bus_wdata : '0;
        assign pset[b]  = (hit && grp == G_PSET) ? bus_wdata : '0;
        assign pclr[b]  = (hit && grp == G_PCLR) ? bus_wdata : '0;
        assign sclr[b]  = (hit && grp == G_SCLR) ? bus_wdata : '0;
        assign ack_v[b] = (hit && grp == G_ACK)  ? bus_wdata : '0;
        assign sw_m[b]  = (hit && grp == G_SENS) ? '1 : '0;
        assign sw_d[b]  = bus_wdata & sw_m[b];
        assign pend_out[b] = |stat_q[b];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '1;
            pol_q  <= '0;
            sens_q <= '0;
            stat_q <= '0;
        end else begin
            mask_q <= (mask_q | mset) & ~mclr;
            pol_q  <= (pol_q | pset) & ~pclr;
            sens_q <= ((sens_q & ~sw_m) | sw_d) & ~sclr;
            stat_q <= flush ? '0 : ((stat_q & ~ack_v) | cap);
        end
    end

    assign mask   = mask_q;
    assign pol    = pol_q;
    assign sens   = sens_q;
    assign status = stat_q;

    always_comb begin
        bus_rdata = '0;
        if (bank_ok) begin
            unique case (grp)
                G_CTRL:         if (bk == 2'd0) bus_rdata = {31'b0, en_q};
                G_MSET, G_MCLR: bus_rdata = mask_q[bk_i];
                G_PSET, G_PCLR: bus_rdata = pol_q[bk_i];
                G_SENS, G_SCLR: bus_rdata = sens_q[bk_i];
                G_STAT:         bus_rdata = stat_q[bk_i];
                default:        bus_rdata = '0;
            endcase
        end
    end

    logic [NL-1:0] mset_f;
    assign mset_f = mset;

    // R8: a flush cycle leaves no captured status behind
    p_flush_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (status == '0));
    // R9: a capture always lands, even against an acknowledge
    p_cap_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((status & $past(cap)) == $past(cap)));
    // R3: no new status bit on a line that was masked
    p_masked_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((status & ~$past(status) & $past(mask)) == '0));
    // R3: mask-set bits are masked after the write
    p_mask_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((mask & $past(mset_f)) == $past(mset_f)));
endmodule

// File: rtl/wake_capture_ctrl.sv
module wake_capture_ctrl #(
    parameter int NUM_BANKS = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_sel,
    input  logic                      bus_wr,
    input  logic [7:0]                bus_addr,
    input  logic [31:0]               bus_wdata,
    output logic [31:0]               bus_rdata,
    input  logic [NUM_BANKS*32-1:0]   irq_in,
    output logic [NUM_BANKS-1:0]      pend_out
);
    localparam int NL = NUM_BANKS * 32;

    logic          ctrl_wr, ctrl_en_bit, ctrl_rst_bit;
    logic          en_q, cap_en, flush;
    logic [NL-1:0] mask, pol, sens, status, cap;

    wcc_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .ctrl_wr      (ctrl_wr),
        .ctrl_en_bit  (ctrl_en_bit),
        .ctrl_rst_bit (ctrl_rst_bit),
        .en_q         (en_q),
        .cap_en       (cap_en),
        .flush        (flush)
    );

    wcc_line_qual #(.NUM_LINES(NL)) u_qual (
        .clk    (clk),
        .rst_n  (rst_n),
        .irq_in (irq_in),
        .mask   (mask),
        .pol    (pol),
        .sens   (sens),
        .cap_en (cap_en),
        .cap    (cap)
    );

    wcc_regfile #(.NUM_BANKS(NUM_BANKS)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_sel      (bus_sel),
        .bus_wr       (bus_wr),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .cap          (cap),
        .flush        (flush),
        .en_q         (en_q),
        .ctrl_wr      (ctrl_wr),
        .ctrl_en_bit  (ctrl_en_bit),
        .ctrl_rst_bit (ctrl_rst_bit),
        .mask         (mask),
        .pol          (pol),
        .sens         (sens),
        .status       (status),
        .pend_out     (pend_out)
    );

    // R7: while capture is off, no status bit appears
    p_no_capture_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_en |=> ((status & ~$past(status)) == '0));
endmodule

// File: tb/test_wake_capture_ctrl.sv
module test_wake_capture_ctrl;
    localparam int NB = 2;
    localparam logic [7:0] A_CTRL = 8'h00, A_MSET = 8'h10, A_MCLR = 8'h20,
        A_PSET = 8'h30, A_PCLR = 8'h40, A_SENS = 8'h50, A_SCLR = 8'h60,
        A_ACK = 8'h70, A_STAT = 8'h80;

    typedef struct packed {
        logic [5:0] line;
        logic       lvl;
        logic       pos;
        logic       start;
        logic       fin;
        logic       exp;
    } row_t;

    localparam row_t ROWS [8] = '{
        '{6'd0,  1'b0, 1'b1, 1'b0, 1'b1, 1'b1},
        '{6'd5,  1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
        '{6'd33, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1},
        '{6'd40, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
        '{6'd63, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1},
        '{6'd31, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1},
        '{6'd32, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0},
        '{6'd12, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_sel = 1'b0, bus_wr = 1'b0;
    logic [7:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NB*32-1:0] irq_in = '0;
    logic [NB-1:0] pend_out;
    int total = 0, bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    wake_capture_ctrl #(.NUM_BANKS(NB)) i_wake_capture_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_in(irq_in), .pend_out(pend_out)
    );

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic chk(input string req, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] got;
        @(negedge clk);
        bus_addr = a;
        #1 got = bus_rdata;
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s addr=%h actual=%h expected=%h", req, a, got, exp);
        end
    endtask

    task automatic chk_pend(input string req, input logic [NB-1:0] exp);
        @(negedge clk);
        total++;
        if (pend_out !== exp) begin
            bad++;
            $display("FAIL %s pend_out actual=%b expected=%b", req, pend_out, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        wait_n(3);
        rst_n = 1'b1;

        // R1 reset state, R2 layout, R11 out-of-range bank
        chk("R1 ctrl", A_CTRL, 32'h0);
        chk("R1 mask bank0", A_MSET, 32'hFFFF_FFFF);
        chk("R1 mask bank1", A_MCLR + 8'h4, 32'hFFFF_FFFF);
        chk("R1 pol", A_PSET, 32'h0);
        chk("R1 sens", A_SENS + 8'h4, 32'h0);
        chk("R1 status", A_STAT, 32'h0);
        chk_pend("R1 pend", 2'b00);
        chk("R11 bank2 read", A_MSET + 8'h8, 32'h0);

        // R7 disabled capture, R3 mask clear, R4 polarity set
        wr(A_PSET, 32'h8);
        wr(A_MCLR, 32'h8);
        chk("R3 mask clear", A_MSET, 32'hFFFF_FFF7);
        chk("R4 pol set", A_PCLR, 32'h8);
        irq_in[3] = 1'b1;
        wait_n(6);
        chk("R7 no capture while off", A_STAT, 32'h0);
        wr(A_CTRL, 32'h1);
        chk("R7 enable reads back", A_CTRL, 32'h1);
        wait_n(3);
        chk("R7 no stale capture", A_STAT, 32'h0);
        irq_in[3] = 1'b0;
        wait_n(4);
        irq_in[3] = 1'b1;
        wait_n(5);
        chk("R5 rising edge", A_STAT, 32'h8);
        chk_pend("R10 pend bank0", 2'b01);

        // R9 acknowledge
        wr(A_ACK, 32'h10);
        chk("R9 ack other bit", A_STAT, 32'h8);
        wr(A_ACK, 32'h8);
        chk("R9 ack clears", A_STAT, 32'h0);
        chk_pend("R10 pend cleared", 2'b00);

        // R9 capture wins over acknowledge on a held level
        wr(A_SENS, 32'h8);
        wait_n(5);
        chk("R6 level capture", A_STAT, 32'h8);
        wr(A_ACK, 32'h8);
        chk("R9 capture beats ack", A_STAT, 32'h8);

        // R4 sensitivity clear, R8 software reset
        wr(A_SCLR, 32'h8);
        chk("R4 sens clear", A_SENS, 32'h0);
        wr(A_CTRL, 32'h3);
        chk("R8 status flushed", A_STAT, 32'h0);
        chk("R8 enable kept", A_CTRL, 32'h1);
        irq_in[3] = 1'b0;
        wait_n(4);
        irq_in[3] = 1'b1;
        wait_n(5);
        chk("R8 armed after flush", A_STAT, 32'h8);

        // R11 unmapped writes ignored, read zero
        wr(8'hF0, 32'hFFFF_FFFF);
        wr(A_MCLR + 8'hC, 32'hFFFF_FFFF);
        wr(A_MCLR + 8'h2, 32'hFFFF_FFFF);
        chk("R11 mask0 untouched", A_MSET, 32'hFFFF_FFF7);
        chk("R11 mask1 untouched", A_MSET + 8'h4, 32'hFFFF_FFFF);
        chk("R11 unmapped reads 0", 8'hF0, 32'h0);
        chk("R11 ack reads 0", A_ACK, 32'h0);
        chk("R11 bank3 reads 0", A_MCLR + 8'hC, 32'h0);

        // R3 re-mask blocks capture
        wr(A_MSET, 32'h8);
        wr(A_ACK, 32'hFFFF_FFFF);
        irq_in[3] = 1'b0;
        wait_n(4);
        irq_in[3] = 1'b1;
        wait_n(5);
        chk("R3 masked line quiet", A_STAT, 32'h0);
        chk_pend("R3 R10 pend quiet", 2'b00);

        // R5 / R6 vector table
        foreach (ROWS[k]) begin
            automatic row_t r = ROWS[k];
            automatic logic [7:0] boff = {5'b0, r.line[5], 2'b00};
            automatic logic [31:0] bit_v = 32'h1 << r.line[4:0];
            wr(A_MSET + boff, bit_v);
            if (r.lvl) wr(A_SENS + boff, bit_v);
            else begin
                wr(A_SENS + boff, 32'h0);
                wr(A_SCLR + boff, bit_v);
            end
            if (r.pos) wr(A_PSET + boff, bit_v);
            else wr(A_PCLR + boff, bit_v);
            irq_in[r.line] = r.start;
            wait_n(5);
            wr(A_ACK, 32'hFFFF_FFFF);
            wr(A_ACK + 8'h4, 32'hFFFF_FFFF);
            @(negedge clk);
            irq_in[r.line] = r.fin;
            wr(A_MCLR + boff, bit_v);
            wait_n(5);
            chk(r.lvl ? "R6 table row" : "R5 table row", A_STAT + boff,
                r.exp ? bit_v : 32'h0);
            chk("R2 other bank clear", A_STAT + (boff ^ 8'h4), 32'h0);
            wr(A_MSET + boff, bit_v);
            wr(A_ACK + boff, 32'hFFFF_FFFF);
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule